// File: doc/BRIEF.md
# Flash Sector Copy Programmer

This block copies a fixed-size region of a byte-addressed source memory into one flash sector, one byte at a time. For every offset it reads the source byte and then reads the byte already in flash at the matching destination offset. When the two already agree, it moves on without touching the flash. When they differ, it hands a byte-program request to a separate command engine, which issues the unlock cycles. It then reads the flash location again and again until that location returns the source byte.

Source and destination offsets advance in lockstep from two base addresses, which are captured when the copy starts. The block emits a one-cycle progress pulse each time another power-of-two group of bytes has been handled. After the final byte it requests a device reset command, and only then does it raise done.

If the command engine reports an error, the copy stops. The block then holds a sticky error flag together with the offset at which the failure happened. Both read ports have a fixed one-cycle read latency.

Top module: `flash_copy_prog`

## Requirements
- R1: While idle, a start pulse captures both base addresses and makes busy high on the next cycle. It also clears done, err and err_offset.
- R2: For offset k, running from 0 up to 2^LEN_W-1 in increasing order, the block reads the source exactly once at src_base+k. Every flash read and program request for that byte targets dst_base+k.
- R3: When the flash byte read at dst_base+k equals the source byte, no program request is made for offset k.
- R4: When the source byte is 0xFF and the sector is erased (all bytes 0xFF), no program request is made. A source that is entirely 0xFF therefore causes zero program requests.
- R5: When the bytes differ, exactly one request is made with cmd_kind=0, cmd_addr=dst_base+k and cmd_data=source byte. The request is held unchanged until cmd_ready is seen.
- R6: After the request is accepted, the block polls the flash at dst_base+k until a read returns the source byte. It does not move to k+1 before that, so the destination finally matches the source.
- R7: progress pulses for one cycle after each offset k whose low PROG_W bits are all ones. A full copy therefore gives 2^(LEN_W-PROG_W) pulses.
- R8: After the last byte, one request is made with cmd_kind=1, cmd_addr=dst_base and cmd_data=0xF0. Done rises once that request is accepted, and it stays high until the next start.
- R9: If eng_err is seen while a program request is pending or being polled, the copy stops. When this happens, busy falls, err latches high with err_offset=k, done stays low and no reset request is made. err stays high until the next start.
- R10: A start pulse while busy has no effect on the running copy or its addresses.
- R11: After reset, busy, done, err, progress, both read enables and cmd_valid are all low.
- R12: In any one cycle, at most one of source read, flash read and command request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (used only while idle) |
| src_base | input | ADDR_W | Source region base address |
| dst_base | input | ADDR_W | Flash sector base address |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | ADDR_W | Source read address |
| src_rd_data | input | DATA_W | Source read data, one cycle after the strobe |
| fl_rd_en | output | 1 | Flash read strobe |
| fl_rd_addr | output | ADDR_W | Flash read address |
| fl_rd_data | input | DATA_W | Flash read data, one cycle after the strobe |
| cmd_valid | output | 1 | Command request to the engine |
| cmd_kind | output | 1 | 0 = byte program, 1 = device reset |
| cmd_addr | output | ADDR_W | Command target address |
| cmd_data | output | DATA_W | Byte to program, or the reset code |
| cmd_ready | input | 1 | Engine accepts the request |
| eng_err | input | 1 | Engine timeout or failure |
| busy | output | 1 | Copy in progress |
| progress | output | 1 | One-cycle pulse per completed group of bytes |
| done | output | 1 | Copy finished; held until next start |
| err | output | 1 | Sticky failure flag |
| err_offset | output | LEN_W | Offset at which the failure happened |

## Verification
A 32-byte region with four-byte progress groups is copied under four flash patterns. The first is an erased sector with a mixed source that contains scattered 0xFF bytes, which separates the skip path from the program path. The second is a sector that already holds the source at even offsets, which shows that skipping is decided per byte and not per run. The third is an all-0xFF source, which must produce no program requests at all. The last is an engine failure injected at one offset, which exposes the stop point and the recorded offset. One run also receives a second start with a different source base while it is busy, to show that the captured addresses stay in force.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOADF,
    ST_CMP,
    ST_PROG,
    ST_POLL,
    ST_CHK,
    ST_ADV,
    ST_RST
  } fcp_state_t;

  localparam logic CMD_PROGRAM = 1'b0;
  localparam logic CMD_RESET   = 1'b1;
  localparam logic [7:0] RESET_CODE = 8'hF0;
endpackage

// File: rtl/fcp_offset_ctr.sv
module fcp_offset_ctr #(
  parameter int LEN_W  = 16,
  parameter int PROG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [LEN_W-1:0] off,
  output logic             is_last,
  output logic             group_end
);
  always_ff @(posedge clk) begin
    if (rst || clr) off <= '0;
    else if (step)  off <= off + 1'b1;
  end

  assign is_last = &off;

  generate
    if (PROG_W == 0) begin : g_every
      assign group_end = 1'b1;
    end else begin : g_group
      assign group_end = &off[PROG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fcp_byte_hold.sv
module fcp_byte_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] probe,
  output logic [DATA_W-1:0] q,
  output logic              same
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assign same = (probe == q);
endmodule

// File: rtl/flash_copy_prog.sv
module flash_copy_prog
  import fcp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int PROG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_rd_addr,
  input  logic [DATA_W-1:0] src_rd_data,
  output logic              fl_rd_en,
  output logic [ADDR_W-1:0] fl_rd_addr,
  input  logic [DATA_W-1:0] fl_rd_data,
  output logic              cmd_valid,
  output logic              cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ready,
  input  logic              eng_err,
  output logic              busy,
  output logic              progress,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  err_offset
);
  localparam logic [DATA_W-1:0] RST_WORD = DATA_W'(RESET_CODE);

  fcp_state_t        st, st_n;
  logic [ADDR_W-1:0] src_q, dst_q, dst_cur;
  logic [LEN_W-1:0]  off;
  logic              is_last, group_end, same;
  logic [DATA_W-1:0] byte_q;
  logic              accept, fail, finish;

  assign accept = (st == ST_IDLE) && start;
  assign fail   = eng_err && ((st == ST_PROG) || (st == ST_POLL) ||
                              (st == ST_CHK)  || (st == ST_RST));
  assign finish = (st == ST_RST) && cmd_ready && !eng_err;

  fcp_offset_ctr #(.LEN_W(LEN_W), .PROG_W(PROG_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .step      (st == ST_ADV),
    .off       (off),
    .is_last   (is_last),
    .group_end (group_end)
  );

  fcp_byte_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (st == ST_LOADF),
    .din   (src_rd_data),
    .probe (fl_rd_data),
    .q     (byte_q),
    .same  (same)
  );

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (start) st_n = ST_FETCH;
      ST_FETCH: st_n = ST_LOADF;
      ST_LOADF: st_n = ST_CMP;
      ST_CMP:   st_n = same ? ST_ADV : ST_PROG;
      ST_PROG:  if (eng_err) st_n = ST_IDLE;
                else if (cmd_ready) st_n = ST_POLL;
      ST_POLL:  st_n = eng_err ? ST_IDLE : ST_CHK;
      ST_CHK:   if (eng_err) st_n = ST_IDLE;
                else st_n = same ? ST_ADV : ST_POLL;
      ST_ADV:   st_n = is_last ? ST_RST : ST_FETCH;
      ST_RST:   if (eng_err || cmd_ready) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      src_q      <= '0;
      dst_q      <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_offset <= '0;
      progress   <= 1'b0;
    end else begin
      st       <= st_n;
      progress <= (st == ST_ADV) && group_end;
      if (accept) begin
        src_q      <= src_base;
        dst_q      <= dst_base;
        done       <= 1'b0;
        err        <= 1'b0;
        err_offset <= '0;
      end
      if (finish) done <= 1'b1;
      if (fail) begin
        err        <= 1'b1;
        err_offset <= off;
      end
    end
  end

  assign dst_cur     = dst_q + ADDR_W'(off);
  assign busy        = (st != ST_IDLE);
  assign src_rd_en   = (st == ST_FETCH);
  assign src_rd_addr = src_q + ADDR_W'(off);
  assign fl_rd_en    = (st == ST_LOADF) || (st == ST_POLL);
  assign fl_rd_addr  = dst_cur;
  assign cmd_valid   = (st == ST_PROG) || (st == ST_RST);
  assign cmd_kind    = (st == ST_RST) ? CMD_RESET : CMD_PROGRAM;
  assign cmd_addr    = (st == ST_RST) ? dst_q : dst_cur;
  assign cmd_data    = (st == ST_RST) ? RST_WORD : byte_q;
endmodule

module fcp_chk
  import fcp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              progress,
  input logic              src_rd_en,
  input logic              fl_rd_en,
  input logic              cmd_valid,
  input logic              cmd_kind,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              eng_err
);
  // R1
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && !eng_err) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_kind)));
  // R7
  progress_busy_chk: assert property (@(posedge clk) disable iff (rst)
    progress |-> busy);
  // R7
  progress_single_chk: assert property (@(posedge clk) disable iff (rst)
    progress |=> !progress);
  // R8
  reset_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind) |-> (cmd_data == DATA_W'(RESET_CODE)));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !eng_err && !(cmd_valid && cmd_kind && cmd_ready)) |=> busy);
  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({src_rd_en, fl_rd_en, cmd_valid}));
endmodule

bind flash_copy_prog fcp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fcp_chk (.*);

// File: tb/flash_copy_prog_test.sv
module flash_copy_prog_test;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int LW = 5;
  localparam int PW = 2;
  localparam int N  = 1 << LW;
  localparam int MEM = 1 << AW;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic src_rd_en, fl_rd_en, cmd_valid, cmd_kind;
  logic [AW-1:0] src_rd_addr, fl_rd_addr, cmd_addr;
  logic [DW-1:0] src_rd_data, fl_rd_data, cmd_data;
  logic cmd_ready, eng_err;
  logic busy, progress, done, err;
  logic [LW-1:0] err_offset;

  always #2.5 clk = ~clk;

  flash_copy_prog #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .PROG_W(PW)) uut (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_ready(cmd_ready), .eng_err(eng_err),
    .busy(busy), .progress(progress), .done(done), .err(err),
    .err_offset(err_offset));

  logic [DW-1:0] src_mem [0:MEM-1];
  logic [DW-1:0] fl_mem  [0:MEM-1];
  int checks = 0, errors = 0, cyc = 0;
  logic [AW-1:0] sb, db;
  bit err_en = 1'b0;
  int err_off = 0;

  // command engine and memory model
  int wait_c;
  int pend;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  always @(posedge clk) begin
    if (rst) begin
      cmd_ready <= 1'b0; wait_c <= 0; pend <= 0; eng_err <= 1'b0;
      src_rd_data <= '0; fl_rd_data <= '0;
    end else begin
      eng_err <= 1'b0;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) fl_mem[pend_addr] <= pend_data;
      end
      if (cmd_valid && cmd_ready) begin
        cmd_ready <= 1'b0; wait_c <= 0;
        if (!cmd_kind) begin
          pend <= 3; pend_addr <= cmd_addr; pend_data <= cmd_data;
          if (err_en && cmd_addr == db + AW'(err_off)) eng_err <= 1'b1;
        end
      end else if (cmd_valid) begin
        if (wait_c == 1) cmd_ready <= 1'b1;
        else wait_c <= wait_c + 1;
      end
      if (src_rd_en) src_rd_data <= src_mem[src_rd_addr];
      if (fl_rd_en)
        fl_rd_data <= (pend != 0 && fl_rd_addr == pend_addr) ? ~pend_data
                                                              : fl_mem[fl_rd_addr];
    end
  end

  // monitor
  int src_seq, addr_bad, prog_total, data_bad, pulses, rst_cmds, rst_bad, overlap;
  int prog_cnt [0:N-1];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (int'(src_rd_en) + int'(fl_rd_en) + int'(cmd_valid) > 1) overlap++;
      if (src_rd_en) begin
        if (src_rd_addr != sb + AW'(src_seq)) addr_bad++;
        src_seq++;
      end
      if (fl_rd_en && fl_rd_addr != db + AW'(src_seq - 1)) addr_bad++;
      if (progress) pulses++;
      if (cmd_valid && cmd_ready) begin
        if (!cmd_kind) begin
          prog_total++;
          if (cmd_addr != db + AW'(src_seq - 1)) addr_bad++;
          else prog_cnt[src_seq - 1]++;
          if (cmd_data != src_mem[sb + AW'(src_seq - 1)]) data_bad++;
        end else begin
          rst_cmds++;
          if (cmd_data != 8'hF0 || cmd_addr != db) rst_bad++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    src_seq = 0; addr_bad = 0; prog_total = 0; data_bad = 0;
    pulses = 0; rst_cmds = 0; rst_bad = 0;
    for (int k = 0; k < N; k++) prog_cnt[k] = 0;
  endtask

  task automatic kick(input logic [AW-1:0] s, input logic [AW-1:0] d);
    sb = s; db = d;
    clear_mon();
    @(negedge clk);
    start = 1'b1; src_base = s; dst_base = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0 && err === 1'b0, "R1 busy after start",
        int'(busy), 1);
  endtask

  task automatic finish_wait();
    while (!done && !err) @(negedge clk);
  endtask

  // full-run checks; expected programs are where source differs from old flash
  task automatic check_full(input logic [DW-1:0] old_fl [0:N-1], input string tag);
    int exp_prog = 0, bad_map = 0, bad_fin = 0;
    for (int k = 0; k < N; k++) begin
      int e = (src_mem[sb + AW'(k)] != old_fl[k]) ? 1 : 0;
      exp_prog += e;
      if (prog_cnt[k] != e) bad_map++;
      if (fl_mem[db + AW'(k)] != src_mem[sb + AW'(k)]) bad_fin++;
    end
    chk(addr_bad == 0 && src_seq == N, {"R2 address walk ", tag}, addr_bad, 0);
    chk(bad_map == 0, {"R3 per-offset skip map ", tag}, bad_map, 0);
    chk(prog_total == exp_prog && data_bad == 0, {"R5 program requests ", tag},
        prog_total, exp_prog);
    chk(bad_fin == 0, {"R6 final flash contents ", tag}, bad_fin, 0);
    chk(pulses == N >> PW, {"R7 progress pulses ", tag}, pulses, N >> PW);
    chk(rst_cmds == 1 && rst_bad == 0, {"R8 reset request ", tag}, rst_cmds, 1);
    repeat (6) @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, {"R8 done held ", tag}, int'(done), 1);
  endtask

  always @(negedge clk) begin
    if (cyc == LIMIT) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [DW-1:0] snap [0:N-1];

  initial begin
    for (int a = 0; a < MEM; a++) begin src_mem[a] = 8'h00; fl_mem[a] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk({busy, done, err, progress, src_rd_en, fl_rd_en, cmd_valid} == 7'b0,
        "R11 reset outputs", int'({busy, done, err, progress}), 0);

    // pattern A: erased sector, mixed source with scattered 0xFF
    for (int k = 0; k < N; k++) begin
      src_mem[12'h100 + k] = (k % 7 == 0) ? 8'hFF : 8'((k * 37 + 5) & 255);
      fl_mem[12'h800 + k] = 8'hFF;
      snap[k] = 8'hFF;
    end
    kick(12'h100, 12'h800);
    finish_wait();
    check_full(snap, "erased/mixed");
    chk(prog_cnt[0] == 0 && prog_cnt[7] == 0, "R4 0xFF bytes skipped",
        prog_cnt[0] + prog_cnt[7], 0);

    // pattern B: even offsets already hold the source
    for (int k = 0; k < N; k++) begin
      fl_mem[12'h800 + k] = (k % 2 == 0) ? src_mem[12'h100 + k] : 8'((k * 11) & 255);
      snap[k] = fl_mem[12'h800 + k];
    end
    kick(12'h100, 12'h800);
    finish_wait();
    check_full(snap, "half-match");

    // pattern C: all-0xFF source to erased sector, plus start while busy
    for (int k = 0; k < N; k++) begin
      src_mem[12'h200 + k] = 8'hFF;
      src_mem[12'h300 + k] = 8'h5A;
      fl_mem[12'hA00 + k] = 8'hFF;
      snap[k] = 8'hFF;
    end
    kick(12'h200, 12'hA00);
    repeat (20) @(negedge clk);
    start = 1'b1; src_base = 12'h300; dst_base = 12'h000;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10 busy kept on second start", int'(busy), 1);
    finish_wait();
    chk(prog_total == 0, "R4 all-0xFF source programs nothing", prog_total, 0);
    chk(addr_bad == 0 && rst_cmds == 1, "R10 captured addresses kept", addr_bad, 0);
    check_full(snap, "all-ff");

    // error injection at offset 9
    for (int k = 0; k < N; k++) begin
      src_mem[12'h100 + k] = 8'((k * 3 + 1) & 255);
      fl_mem[12'hC00 + k] = 8'hFF;
    end
    err_en = 1'b1; err_off = 9;
    kick(12'h100, 12'hC00);
    finish_wait();
    @(negedge clk);
    chk(err === 1'b1 && int'(err_offset) == 9, "R9 error offset", int'(err_offset), 9);
    chk(busy === 1'b0 && done === 1'b0 && rst_cmds == 0, "R9 stopped without reset",
        rst_cmds, 0);
    chk(prog_total == 10, "R9 programs before stop", prog_total, 10);
    repeat (5) @(negedge clk);
    chk(err === 1'b1, "R9 error sticky", int'(err), 1);
    chk(overlap == 0, "R12 port exclusivity", overlap, 0);
    err_en = 1'b0;

    // restart clears error
    kick(12'h100, 12'hC00);
    finish_wait();
    chk(done === 1'b1 && err === 1'b0, "R1 restart after error", int'(err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule